// File: doc/BRIEF.md
# CAN controller control/status register with timestamp timer

This block holds the first control/status byte of a CAN controller and the free-running timer that this byte switches on. A CPU bus port writes the byte with a single strobe and reads it back at any time. Four bits are plain control. Two bits mirror live protocol-engine status. One bit is a sticky flag that records a received valid frame. The remaining bit asks for initialization mode, and the engine confirms that request with an acknowledge input. While the request and the acknowledge are both high, the block holds its status, flag and timer bits at their reset values. Only the wake-up, sleep and init-request bits stay writable during that time.

When the timer bit is set, a 16-bit counter advances once per bit-clock tick. At each end of a valid frame, the counter value is sent to the active message buffer as a timestamp. The high byte is addressed to buffer offset 0x0E and the low byte to offset 0x0F. A one-cycle write strobe marks the update. The buffer side has no back-pressure: it must accept the two bytes in the cycle the strobe is high.

A clock-gate request output carries the stop-in-wait bit to the low-power logic, and only while the chip is in wait mode.

Top module: `can_ctl0_reg`

## Requirements
- R1: After reset, the read value is 0x01 (only init-request, bit 0, set), the timer is zero and no strobe or gate request is active.
- R2: A pulse on `eng_frame_ok` outside initialization mode sets the frame flag (bit 7) at the next clock edge. The flag then stays set until it is cleared.
- R3: A CPU write with bit 7 = 1 clears the frame flag, and a write with bit 7 = 0 leaves it unchanged. If a frame event and a clearing write arrive in the same cycle, the flag stays set.
- R4: Bit 6 reads `eng_rx_busy` and bit 4 reads `eng_synced`. CPU writes to these bits have no effect.
- R5: While init-request and `init_ack` are both 1, bits 7, 6, 5, 4 and 3 read 0 and the frame flag cannot be set. Bits 2, 1 and 0 stay writable. Bits 7, 5 and 3 accept writes again only when both init-request and `init_ack` are 0.
- R6: With timer-enable (bit 3) set, the counter increments on every clock edge where `bit_tick` is high, and wraps from 0xFFFF to 0x0000. With timer-enable clear, the counter is forced to 0.
- R7: An `eng_eof` pulse while the timer is enabled raises `stamp_wr` for one cycle after the next edge. The bytes carry the counter value from the eof cycle, before any tick in that same cycle takes effect: the high byte on `stamp_hi_0e` and the low byte on `stamp_lo_0f`. While the timer is disabled, `eng_eof` produces no strobe.
- R8: `clk_gate_req` is high exactly when the stop-in-wait bit (bit 5) is set and `wait_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | CPU write strobe for the register |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Current register read value |
| eng_rx_busy | input | 1 | Engine is receiving a message |
| eng_synced | input | 1 | Engine is synchronized to the bus |
| eng_frame_ok | input | 1 | Pulse: valid frame received |
| eng_eof | input | 1 | Pulse: end of frame of a valid message |
| bit_tick | input | 1 | One-cycle bit-clock tick enable |
| init_ack | input | 1 | Engine acknowledges initialization mode |
| wait_mode | input | 1 | Chip is in wait mode |
| init_req_o | output | 1 | Initialization-mode request to the engine |
| wake_en_o | output | 1 | Wake-up enable |
| sleep_req_o | output | 1 | Sleep-mode request |
| clk_gate_req | output | 1 | Request to gate the bus-interface clock |
| stamp_wr | output | 1 | One-cycle timestamp write strobe |
| stamp_hi_0e | output | 8 | Timestamp high byte, buffer offset 0x0E |
| stamp_lo_0f | output | 8 | Timestamp low byte, buffer offset 0x0F |

## Verification
A corrupted counter is invisible on the register port. It first shows as a wrong timestamp at the next `eng_eof`, so the bench stamps frames after known numbers of ticks, after a tick that coincides with eof, and across the 16-bit wrap. A mis-held control bit shows on the very next read or on `clk_gate_req` within one cycle. For that reason every init-mode step and every write-0/write-1 step is followed directly by a read. A missed or duplicated strobe shows in the cycle after eof, and the scoreboard catches it as an unexpected or missing entry.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

  // Bit positions in the register view (the CPU decodes these)
  localparam int unsigned RXF_POS    = 7;
  localparam int unsigned RXBUSY_POS = 6;
  localparam int unsigned STOPW_POS  = 5;
  localparam int unsigned SYNC_POS   = 4;
  localparam int unsigned TMREN_POS  = 3;
  localparam int unsigned WAKE_POS   = 2;
  localparam int unsigned SLEEP_POS  = 1;
  localparam int unsigned INIT_POS   = 0;

  // Stored (non-mirror) bits of the register
  typedef struct packed {
    logic rx_flag;
    logic stop_wait;
    logic tmr_en;
    logic wake_en;
    logic sleep_req;
    logic init_req;
  } ctl_state_t;

  localparam ctl_state_t CTL_RESET = '{rx_flag: 1'b0, stop_wait: 1'b0,
                                       tmr_en: 1'b0, wake_en: 1'b0,
                                       sleep_req: 1'b0, init_req: 1'b1};

  function automatic logic [7:0] view_byte(ctl_state_t s, logic busy, logic sync);
    logic [7:0] v;
    v              = '0;
    v[RXF_POS]     = s.rx_flag;
    v[RXBUSY_POS]  = busy;
    v[STOPW_POS]   = s.stop_wait;
    v[SYNC_POS]    = sync;
    v[TMREN_POS]   = s.tmr_en;
    v[WAKE_POS]    = s.wake_en;
    v[SLEEP_POS]   = s.sleep_req;
    v[INIT_POS]    = s.init_req;
    return v;
  endfunction

endpackage

// File: rtl/ctl_reg_bits.sv
module ctl_reg_bits
  import canctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       frame_ok,
  input  logic       init_ack,
  output ctl_state_t st,
  output logic       init_mode
);

  logic open_wr;
  logic unused_ro_bits;

  assign init_mode      = st.init_req & init_ack;
  // Held bits accept writes only once request and acknowledge are both low
  assign open_wr        = ~st.init_req & ~init_ack;
  assign unused_ro_bits = wdata[RXBUSY_POS] ^ wdata[SYNC_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= CTL_RESET;
    end else begin
      if (wr_en) begin
        st.wake_en   <= wdata[WAKE_POS];
        st.sleep_req <= wdata[SLEEP_POS];
        st.init_req  <= wdata[INIT_POS];
      end
      if (init_mode) begin
        st.rx_flag   <= 1'b0;
        st.stop_wait <= 1'b0;
        st.tmr_en    <= 1'b0;
      end else begin
        if (wr_en && open_wr) begin
          st.stop_wait <= wdata[STOPW_POS];
          st.tmr_en    <= wdata[TMREN_POS];
        end
        if (frame_ok)
          st.rx_flag <= 1'b1;
        else if (wr_en && open_wr && wdata[RXF_POS])
          st.rx_flag <= 1'b0;
      end
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !init_mode) |=> st.rx_flag);

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && open_wr && wdata[RXF_POS] && !frame_ok) |=> !st.rx_flag);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rx_flag && !wr_en && !init_mode) |=> st.rx_flag);

  assert_init_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> (!st.rx_flag && !st.stop_wait && !st.tmr_en));

  assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_wr && !init_mode) |=> ($stable(st.tmr_en) && $stable(st.stop_wait)));

endmodule

// File: rtl/stamp_timer.sv
module stamp_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             eof,
  output logic             stamp_wr,
  output logic [CNT_W-1:0] stamp
);

  localparam int unsigned LANES = CNT_W / 8;

  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take = eof & run;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stamp_wr <= 1'b0;
    else        stamp_wr <= take;
  end

  // One capture register per buffer byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)    stamp[g*8 +: 8] <= '0;
      else if (take) stamp[g*8 +: 8] <= cnt[g*8 +: 8];
    end
  end

  assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_wr |-> $past(eof && run));

  assert_stamp_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (stamp == $past(cnt)));

endmodule

// File: rtl/can_ctl0_reg.sv
module can_ctl0_reg
  import canctl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       eng_rx_busy,
  input  logic       eng_synced,
  input  logic       eng_frame_ok,
  input  logic       eng_eof,
  input  logic       bit_tick,
  input  logic       init_ack,
  input  logic       wait_mode,
  output logic       init_req_o,
  output logic       wake_en_o,
  output logic       sleep_req_o,
  output logic       clk_gate_req,
  output logic       stamp_wr,
  output logic [7:0] stamp_hi_0e,
  output logic [7:0] stamp_lo_0f
);

  ctl_state_t       st;
  logic             init_mode;
  logic [CNT_W-1:0] stamp;

  ctl_reg_bits u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .wdata     (bus_wdata),
    .frame_ok  (eng_frame_ok),
    .init_ack  (init_ack),
    .st        (st),
    .init_mode (init_mode)
  );

  stamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st.tmr_en),
    .tick     (bit_tick),
    .eof      (eng_eof),
    .stamp_wr (stamp_wr),
    .stamp    (stamp)
  );

  // Status mirrors read as reset value while initialization mode is active
  assign bus_rdata    = view_byte(st, eng_rx_busy & ~init_mode, eng_synced & ~init_mode);
  assign init_req_o   = st.init_req;
  assign wake_en_o    = st.wake_en;
  assign sleep_req_o  = st.sleep_req;
  assign clk_gate_req = st.stop_wait & wait_mode;
  assign stamp_hi_0e  = stamp[CNT_W-1 -: 8];
  assign stamp_lo_0f  = stamp[7:0];

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_req |-> (wait_mode && bus_rdata[STOPW_POS]));

  assert_ro_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |-> (bus_rdata[RXBUSY_POS] == 1'b0 && bus_rdata[SYNC_POS] == 1'b0));

endmodule

// File: tb/can_ctl0_reg_tb.sv
module can_ctl0_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       eng_rx_busy, eng_synced, eng_frame_ok, eng_eof, bit_tick;
  logic       init_ack, wait_mode;
  logic       init_req_o, wake_en_o, sleep_req_o, clk_gate_req;
  logic       stamp_wr;
  logic [7:0] stamp_hi_0e, stamp_lo_0f;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  can_ctl0_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_rx_busy(eng_rx_busy), .eng_synced(eng_synced),
    .eng_frame_ok(eng_frame_ok), .eng_eof(eng_eof), .bit_tick(bit_tick),
    .init_ack(init_ack), .wait_mode(wait_mode), .init_req_o(init_req_o),
    .wake_en_o(wake_en_o), .sleep_req_o(sleep_req_o), .clk_gate_req(clk_gate_req),
    .stamp_wr(stamp_wr), .stamp_hi_0e(stamp_hi_0e), .stamp_lo_0f(stamp_lo_0f)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // Driver: eof pulse, pushing the expected stamp when one is due
  task automatic eof_pulse(bit expect_stamp, logic [15:0] val, bit with_tick);
    if (expect_stamp) exp_q.push_back(val);
    eng_eof = 1'b1; bit_tick = with_tick;
    @(negedge clk);
    eng_eof = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic frame_pulse();
    eng_frame_ok = 1'b1;
    @(negedge clk);
    eng_frame_ok = 1'b0;
  endtask

  // Monitor: every strobe must match the oldest expected stamp (R7)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && stamp_wr === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected strobe", 32'd1, 32'd0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R7 stamp bytes 0x0E/0x0F", {16'h0, stamp_hi_0e, stamp_lo_0f}, {16'h0, e});
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    eng_rx_busy = 0; eng_synced = 0; eng_frame_ok = 0; eng_eof = 0;
    bit_tick = 0; init_ack = 0; wait_mode = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h01);
    chk("R1 init_req_o", init_req_o, 1);
    chk("R1 strobe/gate", {stamp_wr, clk_gate_req}, 0);

    wr(8'h00);
    chk("R1 leave init", bus_rdata, 8'h00);

    // R4 read-only mirrors
    eng_rx_busy = 1; eng_synced = 1;
    @(negedge clk);
    chk("R4 mirrors", bus_rdata, 8'h50);
    wr(8'h00);
    chk("R4 write 0 ignored", bus_rdata, 8'h50);
    eng_rx_busy = 0; eng_synced = 0;
    wr(8'h50);
    chk("R4 write 1 ignored", bus_rdata, 8'h00);

    // R2 sticky flag, R3 clear rules
    frame_pulse();
    chk("R2 flag set", bus_rdata, 8'h80);
    repeat (5) @(negedge clk);
    chk("R2 flag sticky", bus_rdata, 8'h80);
    wr(8'h00);
    chk("R3 write 0 keeps flag", bus_rdata, 8'h80);
    wr(8'h80);
    chk("R3 write 1 clears", bus_rdata, 8'h00);
    eng_frame_ok = 1'b1;
    wr(8'h80);
    eng_frame_ok = 1'b0;
    chk("R3 set wins over clear", bus_rdata, 8'h80);
    wr(8'h80);

    // R8 clock gate request
    wr(8'h20);
    chk("R8 stop bit read", bus_rdata, 8'h20);
    chk("R8 no wait", clk_gate_req, 0);
    wait_mode = 1;
    @(negedge clk);
    chk("R8 wait", clk_gate_req, 1);
    wr(8'h00);
    chk("R8 bit cleared", clk_gate_req, 0);
    wait_mode = 0;

    // R6/R7 timer and timestamp
    wr(8'h08);
    ticks(100);
    eof_pulse(1, 16'd100, 0);
    for (int i = 0; i < 50; i++) begin
      bit_tick = 1; @(negedge clk);
      bit_tick = 0; @(negedge clk);
    end
    eof_pulse(1, 16'd150, 1);   // tick in same cycle: pre-increment value
    eof_pulse(1, 16'd151, 0);
    wr(8'h00);
    ticks(10);
    eof_pulse(0, 16'd0, 0);     // timer off: no strobe
    @(negedge clk);
    wr(8'h08);
    eof_pulse(1, 16'd0, 0);     // R6 counter was forced to zero
    wr(8'h00);
    wr(8'h08);
    ticks(65539);
    eof_pulse(1, 16'd3, 0);     // R6 wrap
    @(negedge clk);
    chk("R7 queue drained", exp_q.size(), 0);

    // R5 initialization mode
    wr(8'h28);
    frame_pulse();
    eng_rx_busy = 1;
    wr(8'h29);
    init_ack = 1;
    @(negedge clk);
    chk("R5 held in init", bus_rdata, 8'h01);
    wr(8'hFF);
    chk("R5 low bits writable", bus_rdata, 8'h07);
    wait_mode = 1;
    frame_pulse();
    eof_pulse(0, 16'd0, 0);
    chk("R5 frame ignored, gate off", {bus_rdata, 7'h0, clk_gate_req}, {8'h07, 8'h00});
    wr(8'h00);
    chk("R5 req low ack high", bus_rdata, 8'h40);
    wr(8'h28);
    chk("R5 still locked", bus_rdata, 8'h40);
    init_ack = 0;
    @(negedge clk);
    wr(8'h28);
    chk("R5 writable again", bus_rdata, 8'h68);
    chk("R8 gate after init", clk_gate_req, 1);
    chk("R7 no stray stamps", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule